// File: doc/BRIEF.md
# Peripheral Control Register Bank

This block is a halfword-wide memory-mapped register file that sits between a simple synchronous bus and the control and status wiring of a handheld-console-style chip. It holds the interrupt enable, flag and master-enable registers, the button status word, one control word per timer, a display status word, a sound master control word, a write-only DMA transfer count and a low-power command byte. The engines that use these values are outside the block. Their status bits come in on input ports, and the stored control words go out on output ports.

Every access names a byte address. A write is either a full halfword or a single byte carried on `bus_wdata_i[7:0]`. A byte write is first merged into a halfword and then goes through the same per-register write path as a halfword write. Each register applies its own rule to a write: a keep-mask, read-only status bits, write-one-to-clear, write-only readback, or a command pulse with no storage. Reads are registered.

A two-state read-response machine drives the response side. It has two states:
- `BUS_IDLE`: no data is valid.
- `BUS_RESP`: `bus_rdata_o` holds the word read on the previous edge.

It has three transitions:
- `BUS_IDLE -> BUS_RESP` when a read is requested.
- `BUS_RESP -> BUS_RESP` on a back-to-back read.
- `BUS_RESP -> BUS_IDLE` when no read is requested.

Register map (byte offsets, with NTMR = 4 timers):

| Offset | Register |
|---|---|
| 0x000 | display status |
| 0x002 | sound master control |
| 0x004 | DMA count |
| 0x006 | buttons |
| 0x008 + 2k | timer k |
| 0x010 | interrupt enable |
| 0x012 | interrupt flags |
| 0x014 | master enable |
| 0x016 | low-power command |
| 0x018 and above | unmapped |

Top module: `pcr_bank`

## Requirements
- R1: A read requested on a rising edge sets `bus_rvalid_o` and presents its data from that edge until the next edge. `bus_rvalid_o` is low in any cycle that follows an edge without a read. After reset every stored register is zero, except the button register, which is 0x03FF.
- R2: A halfword write to the flag register (0x012) clears each flag whose data bit is 1 and leaves flags whose data bit is 0 unchanged.
- R3: A high bit of `irq_src_i` sets the matching flag on that edge. When a set and a clear hit the same flag on the same edge, the set wins.
- R4: `irq_o` is high when bit 0 of the master-enable register (0x014) is 1 and enable AND flags is non-zero. Master enable stores only bit 0. Enable (0x010) stores NIRQ = 14 bits and reads back zero-extended.
- R5: A byte write (`bus_byte_i` = 1) takes its byte from `bus_wdata_i[7:0]`. Address bit 0 picks the lane: 0 is the low lane, 1 is the high lane. The other lane takes the register's currently stored value. The merged halfword then follows the normal write rule of that register.
- R6: At 0x016, only a byte write with address bit 0 = 0 acts, and it looks only at data bit 7. Bit 7 = 0 gives a one-cycle `halt_req_o` pulse after the edge. Bit 7 = 1 gives a one-cycle `stop_req_o` pulse. Halfword writes there and byte writes to 0x017 do nothing. Reads of 0x016 return 0.
- R7: Timer k (0x008 + 2k) stores write data ANDed with 0x00C7. The value appears on `tmr_ctl_o[16k +: 16]` and reads back unchanged.
- R8: Display status (0x000) stores write data ANDed with 0xFFF8 on `disp_ctl_o`. It reads back as the stored value ORed with `disp_stat_i` in bits 2:0.
- R9: The button register (0x006) samples `key_n_i` on every edge, with 1 meaning released. A read returns that sample zero-extended to 16 bits. Writes have no effect.
- R10: The DMA count (0x004) stores write data on `dma_cnt_o` and always reads as 0.
- R11: Sound master control (0x002) stores write data ANDed with 0xFFF0 on `snd_ctl_o`. It reads back as the stored value ORed with `snd_stat_i` in bits 3:0.
- R12: Reads of any address at or above 0x018 return 0. Writes there change no register, including addresses whose low bits match a mapped register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_we_i | input | 1 | Write request |
| bus_re_i | input | 1 | Read request |
| bus_byte_i | input | 1 | 1 = byte write, 0 = halfword write |
| bus_addr_i | input | ADDR_W (10) | Byte address |
| bus_wdata_i | input | 16 | Write data; a byte write uses bits 7:0 |
| bus_rdata_o | output | 16 | Registered read data |
| bus_rvalid_o | output | 1 | Read data valid |
| irq_src_i | input | NIRQ (14) | Per-source flag set pulses |
| key_n_i | input | NKEY (10) | Button lines, 1 = released |
| disp_stat_i | input | 3 | Display status bits |
| snd_stat_i | input | 4 | Sound status bits |
| irq_o | output | 1 | Interrupt request |
| halt_req_o | output | 1 | Halt request pulse |
| stop_req_o | output | 1 | Stop request pulse |
| tmr_ctl_o | output | NTMR*16 (64) | Timer control words, timer k in bits 16k+15:16k |
| disp_ctl_o | output | 16 | Stored display status control bits |
| snd_ctl_o | output | 16 | Stored sound master control bits |
| dma_cnt_o | output | 16 | Stored DMA count |

## Verification
The properties assume that a write request comes with a stable address, data and byte flag for the whole cycle, and that `bus_byte_i` is meaningful only together with `bus_we_i`. They also assume that status and source inputs change only between edges. The stimulus meets these assumptions by driving every bus field and every status input on the falling edge only. It raises a request for exactly one cycle and drops it before the next access. The only case where the flag-set pulse and a flag write share an edge is the deliberate set-versus-clear collision.

// File: rtl/pcr_pkg.sv
package pcr_pkg;

    typedef enum logic [0:0] {
        BUS_IDLE = 1'b0,
        BUS_RESP = 1'b1
    } bus_state_e;

    localparam logic [15:0] DISP_KEEP = 16'hFFF8;
    localparam logic [15:0] SND_KEEP  = 16'hFFF0;
    localparam logic [15:0] TMR_KEEP  = 16'h00C7;

    localparam int DISP_OFF = 0;
    localparam int SND_OFF  = 2;
    localparam int DMA_OFF  = 4;
    localparam int KEY_OFF  = 6;
    localparam int TMR_OFF  = 8;

endpackage

// File: rtl/pcr_wr_merge.sv
module pcr_wr_merge (
    input  logic        byte_i,
    input  logic        lane_i,
    input  logic [15:0] wdata_i,
    input  logic [15:0] cur_i,
    output logic [15:0] merged_o
);
    always_comb begin
        merged_o = wdata_i;
        if (byte_i) begin
            merged_o = lane_i ? {wdata_i[7:0], cur_i[7:0]}
                              : {cur_i[15:8], wdata_i[7:0]};
        end
    end
endmodule

// File: rtl/pcr_irq_ctl.sv
module pcr_irq_ctl #(
    parameter int NIRQ = 14
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            ie_we_i,
    input  logic            if_we_i,
    input  logic            ime_we_i,
    input  logic [NIRQ-1:0] wd_i,
    input  logic [NIRQ-1:0] src_i,
    output logic [NIRQ-1:0] ie_o,
    output logic [NIRQ-1:0] if_o,
    output logic            ime_o,
    output logic            irq_o
);
    logic [NIRQ-1:0] ie_q, if_q;
    logic            ime_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            ie_q  <= '0;
            if_q  <= '0;
            ime_q <= 1'b0;
        end else begin
            if (ie_we_i)  ie_q  <= wd_i;
            if (ime_we_i) ime_q <= wd_i[0];
            if_q <= (if_we_i ? (if_q & ~wd_i) : if_q) | src_i;
        end
    end

    assign ie_o  = ie_q;
    assign if_o  = if_q;
    assign ime_o = ime_q;
    assign irq_o = ime_q & (|(ie_q & if_q));
endmodule

// File: rtl/pcr_lp_ctl.sv
module pcr_lp_ctl (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic hit_i,
    input  logic stop_sel_i,
    output logic halt_o,
    output logic stop_o
);
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            halt_o <= 1'b0;
            stop_o <= 1'b0;
        end else begin
            halt_o <= hit_i & ~stop_sel_i;
            stop_o <= hit_i &  stop_sel_i;
        end
    end
endmodule

// File: rtl/pcr_bank.sv
module pcr_bank
    import pcr_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int NIRQ   = 14,
    parameter int NTMR   = 4,
    parameter int NKEY   = 10
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               bus_we_i,
    input  logic               bus_re_i,
    input  logic               bus_byte_i,
    input  logic [ADDR_W-1:0]  bus_addr_i,
    input  logic [15:0]        bus_wdata_i,
    output logic [15:0]        bus_rdata_o,
    output logic               bus_rvalid_o,
    input  logic [NIRQ-1:0]    irq_src_i,
    input  logic [NKEY-1:0]    key_n_i,
    input  logic [2:0]         disp_stat_i,
    input  logic [3:0]         snd_stat_i,
    output logic               irq_o,
    output logic               halt_req_o,
    output logic               stop_req_o,
    output logic [NTMR*16-1:0] tmr_ctl_o,
    output logic [15:0]        disp_ctl_o,
    output logic [15:0]        snd_ctl_o,
    output logic [15:0]        dma_cnt_o
);
    localparam logic [ADDR_W-1:0] A_DISP = ADDR_W'(DISP_OFF);
    localparam logic [ADDR_W-1:0] A_SND  = ADDR_W'(SND_OFF);
    localparam logic [ADDR_W-1:0] A_DMA  = ADDR_W'(DMA_OFF);
    localparam logic [ADDR_W-1:0] A_KEY  = ADDR_W'(KEY_OFF);
    localparam int                IRQ_OFF = TMR_OFF + 2 * NTMR;
    localparam logic [ADDR_W-1:0] A_IE   = ADDR_W'(IRQ_OFF);
    localparam logic [ADDR_W-1:0] A_IF   = ADDR_W'(IRQ_OFF + 2);
    localparam logic [ADDR_W-1:0] A_IME  = ADDR_W'(IRQ_OFF + 4);
    localparam logic [ADDR_W-1:0] A_LP   = ADDR_W'(IRQ_OFF + 6);

    logic [ADDR_W-1:0] addr_hw;
    logic [15:0]       cur_hw, merged, rd_mux, rdata_q;
    logic [15:0]       disp_q, snd_q, dma_q;
    logic [NKEY-1:0]   key_q;
    logic [NIRQ-1:0]   ie_w, if_w;
    logic              ime_w;
    bus_state_e        st_q, st_nx;

    assign addr_hw = {bus_addr_i[ADDR_W-1:1], 1'b0};

    // current stored halfword, used as the kept lane of a byte write
    always_comb begin
        cur_hw = '0;
        if (addr_hw == A_DISP) cur_hw = disp_q;
        if (addr_hw == A_SND)  cur_hw = snd_q;
        if (addr_hw == A_DMA)  cur_hw = dma_q;
        if (addr_hw == A_IE)   cur_hw = 16'(ie_w);
        if (addr_hw == A_IF)   cur_hw = 16'(if_w);
        if (addr_hw == A_IME)  cur_hw = 16'(ime_w);
        for (int k = 0; k < NTMR; k++) begin
            if (addr_hw == ADDR_W'(TMR_OFF + 2 * k)) cur_hw = tmr_ctl_o[16*k +: 16];
        end
    end

    pcr_wr_merge u_merge (
        .byte_i   (bus_byte_i),
        .lane_i   (bus_addr_i[0]),
        .wdata_i  (bus_wdata_i),
        .cur_i    (cur_hw),
        .merged_o (merged)
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            disp_q <= '0;
            snd_q  <= '0;
            dma_q  <= '0;
            key_q  <= '1;
        end else begin
            key_q <= key_n_i;
            if (bus_we_i && addr_hw == A_DISP) disp_q <= merged & DISP_KEEP;
            if (bus_we_i && addr_hw == A_SND)  snd_q  <= merged & SND_KEEP;
            if (bus_we_i && addr_hw == A_DMA)  dma_q  <= merged;
        end
    end

    for (genvar g = 0; g < NTMR; g++) begin : g_tmr
        logic [15:0] ctl_q;
        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
                ctl_q <= '0;
            end else if (bus_we_i && addr_hw == ADDR_W'(TMR_OFF + 2 * g)) begin
                ctl_q <= merged & TMR_KEEP;
            end
        end
        assign tmr_ctl_o[16*g +: 16] = ctl_q;
    end

    pcr_irq_ctl #(.NIRQ(NIRQ)) u_irq (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .ie_we_i  (bus_we_i && addr_hw == A_IE),
        .if_we_i  (bus_we_i && addr_hw == A_IF),
        .ime_we_i (bus_we_i && addr_hw == A_IME),
        .wd_i     (merged[NIRQ-1:0]),
        .src_i    (irq_src_i),
        .ie_o     (ie_w),
        .if_o     (if_w),
        .ime_o    (ime_w),
        .irq_o    (irq_o)
    );

    pcr_lp_ctl u_lp (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .hit_i      (bus_we_i && bus_byte_i && bus_addr_i == A_LP),
        .stop_sel_i (bus_wdata_i[7]),
        .halt_o     (halt_req_o),
        .stop_o     (stop_req_o)
    );

    // readback view; DMA count, low-power and unmapped space stay 0
    always_comb begin
        rd_mux = '0;
        if (addr_hw == A_DISP) rd_mux = disp_q | {13'd0, disp_stat_i};
        if (addr_hw == A_SND)  rd_mux = snd_q | {12'd0, snd_stat_i};
        if (addr_hw == A_KEY)  rd_mux = 16'(key_q);
        if (addr_hw == A_IE)   rd_mux = 16'(ie_w);
        if (addr_hw == A_IF)   rd_mux = 16'(if_w);
        if (addr_hw == A_IME)  rd_mux = 16'(ime_w);
        for (int k = 0; k < NTMR; k++) begin
            if (addr_hw == ADDR_W'(TMR_OFF + 2 * k)) rd_mux = tmr_ctl_o[16*k +: 16];
        end
    end

    // read-response state register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q    <= BUS_IDLE;
            rdata_q <= '0;
        end else begin
            st_q <= st_nx;
            if (bus_re_i) rdata_q <= rd_mux;
        end
    end

    always_comb begin
        unique case (st_q)
            BUS_IDLE: st_nx = bus_re_i ? BUS_RESP : BUS_IDLE;
            BUS_RESP: st_nx = bus_re_i ? BUS_RESP : BUS_IDLE;
            default:  st_nx = BUS_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        bus_rvalid_o = (st_q == BUS_RESP);
        bus_rdata_o  = rdata_q;
        disp_ctl_o   = disp_q;
        snd_ctl_o    = snd_q;
        dma_cnt_o    = dma_q;
    end
endmodule

// File: rtl/pcr_bank_chk.sv
module pcr_bank_chk
    import pcr_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int NTMR   = 4
) (
    input logic               clk_i,
    input logic               rst_ni,
    input logic               bus_we_i,
    input logic               bus_re_i,
    input logic               bus_byte_i,
    input logic [ADDR_W-1:0]  bus_addr_i,
    input logic [15:0]        bus_wdata_i,
    input logic [15:0]        bus_rdata_o,
    input logic               bus_rvalid_o,
    input logic               halt_req_o,
    input logic               stop_req_o,
    input logic [NTMR*16-1:0] tmr_ctl_o
);
    localparam logic [ADDR_W-1:0] C_LP  = ADDR_W'(TMR_OFF + 2 * NTMR + 6);
    localparam logic [ADDR_W-1:0] C_END = ADDR_W'(TMR_OFF + 2 * NTMR + 8);
    localparam logic [ADDR_W-2:0] C_DMA = (ADDR_W-1)'(DMA_OFF / 2);

    logic lp_hit;
    assign lp_hit = bus_we_i && bus_byte_i && bus_addr_i == C_LP;

    AST_RVALID_NEXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        bus_re_i |=> bus_rvalid_o); // R1
    AST_RVALID_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !bus_re_i |=> !bus_rvalid_o); // R1
    AST_HALT_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (lp_hit && !bus_wdata_i[7]) |=> (halt_req_o && !stop_req_o)); // R6
    AST_STOP_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (lp_hit && bus_wdata_i[7]) |=> (stop_req_o && !halt_req_o)); // R6
    AST_LP_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !lp_hit |=> (!halt_req_o && !stop_req_o)); // R6
    AST_DMA_RD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bus_re_i && bus_addr_i[ADDR_W-1:1] == C_DMA) |=> (bus_rdata_o == 16'h0000)); // R10
    AST_HIGH_RD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bus_re_i && bus_addr_i >= C_END) |=> (bus_rdata_o == 16'h0000)); // R12

    for (genvar g = 0; g < NTMR; g++) begin : g_chk
        AST_TMR_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (bus_we_i && !bus_byte_i && bus_addr_i[ADDR_W-1:1] == (ADDR_W-1)'((TMR_OFF + 2 * g) / 2))
            |=> (tmr_ctl_o[16*g +: 16] == ($past(bus_wdata_i) & TMR_KEEP))); // R7
    end
endmodule

bind pcr_bank pcr_bank_chk #(.ADDR_W(ADDR_W), .NTMR(NTMR)) u_chk (.*);

// File: tb/pcr_bank_tb_top.sv
`timescale 1ns/1ps
module pcr_bank_tb_top;
    localparam int ADDR_W = 10;
    localparam int NIRQ   = 14;
    localparam int NTMR   = 4;
    localparam int NKEY   = 10;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               we = 1'b0, re = 1'b0, bt = 1'b0;
    logic [ADDR_W-1:0]  addr = '0;
    logic [15:0]        wdata = '0;
    logic [15:0]        rdata;
    logic               rvalid;
    logic [NIRQ-1:0]    src = '0;
    logic [NKEY-1:0]    keys = '0;
    logic [2:0]         dstat = '0;
    logic [3:0]         sstat = '0;
    logic               irq, halt, stop;
    logic [NTMR*16-1:0] tmr;
    logic [15:0]        dctl, sctl, dcnt;

    int  n_run = 0, n_fail = 0;
    bit  done = 1'b0;

    always #4 clk = ~clk;

    pcr_bank #(.ADDR_W(ADDR_W), .NIRQ(NIRQ), .NTMR(NTMR), .NKEY(NKEY)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .bus_we_i(we), .bus_re_i(re), .bus_byte_i(bt),
        .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata), .bus_rvalid_o(rvalid),
        .irq_src_i(src), .key_n_i(keys), .disp_stat_i(dstat), .snd_stat_i(sstat),
        .irq_o(irq), .halt_req_o(halt), .stop_req_o(stop), .tmr_ctl_o(tmr),
        .disp_ctl_o(dctl), .snd_ctl_o(sctl), .dma_cnt_o(dcnt)
    );

    typedef struct packed {
        logic              wr;
        logic              bt;
        logic [ADDR_W-1:0] addr;
        logic [15:0]       data;
        logic [15:0]       exp;
        logic [3:0]        req;
    } vec_t;

    localparam int NV = 28;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 1'b0, 10'h000, 16'hFFFF, 16'h0000, 4'd8},
        '{1'b0, 1'b0, 10'h000, 16'h0000, 16'hFFFD, 4'd8},   // R8
        '{1'b1, 1'b1, 10'h001, 16'hEE12, 16'h0000, 4'd5},
        '{1'b0, 1'b0, 10'h000, 16'h0000, 16'h12FD, 4'd5},   // R5 high lane
        '{1'b1, 1'b0, 10'h002, 16'h1234, 16'h0000, 4'd11},
        '{1'b0, 1'b0, 10'h002, 16'h0000, 16'h123A, 4'd11},  // R11
        '{1'b1, 1'b0, 10'h004, 16'hABCD, 16'h0000, 4'd10},
        '{1'b0, 1'b0, 10'h004, 16'h0000, 16'h0000, 4'd10},  // R10
        '{1'b1, 1'b0, 10'h008, 16'hFFFF, 16'h0000, 4'd7},
        '{1'b0, 1'b0, 10'h008, 16'h0000, 16'h00C7, 4'd7},   // R7
        '{1'b1, 1'b0, 10'h00E, 16'h1234, 16'h0000, 4'd7},
        '{1'b0, 1'b0, 10'h00E, 16'h0000, 16'h0004, 4'd7},   // R7
        '{1'b1, 1'b1, 10'h00E, 16'h5583, 16'h0000, 4'd5},
        '{1'b0, 1'b0, 10'h00E, 16'h0000, 16'h0083, 4'd5},   // R5 low lane
        '{1'b1, 1'b0, 10'h006, 16'h0000, 16'h0000, 4'd9},
        '{1'b0, 1'b0, 10'h006, 16'h0000, 16'h02F5, 4'd9},   // R9
        '{1'b1, 1'b0, 10'h010, 16'h0F0F, 16'h0000, 4'd4},
        '{1'b0, 1'b0, 10'h010, 16'h0000, 16'h0F0F, 4'd4},   // R4
        '{1'b1, 1'b1, 10'h011, 16'h0030, 16'h0000, 4'd5},
        '{1'b0, 1'b0, 10'h010, 16'h0000, 16'h300F, 4'd5},   // R5
        '{1'b1, 1'b0, 10'h014, 16'hFFFF, 16'h0000, 4'd4},
        '{1'b0, 1'b0, 10'h014, 16'h0000, 16'h0001, 4'd4},   // R4
        '{1'b0, 1'b0, 10'h016, 16'h0000, 16'h0000, 4'd6},   // R6
        '{1'b1, 1'b0, 10'h018, 16'hFFFF, 16'h0000, 4'd12},
        '{1'b0, 1'b0, 10'h018, 16'h0000, 16'h0000, 4'd12},  // R12
        '{1'b0, 1'b0, 10'h3FE, 16'h0000, 16'h0000, 4'd12},  // R12
        '{1'b1, 1'b0, 10'h012, 16'hFFFF, 16'h0000, 4'd2},
        '{1'b0, 1'b0, 10'h012, 16'h0000, 16'h0000, 4'd2}    // R2
    };

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [15:0] d, input logic b);
        @(negedge clk);
        we = 1'b1; bt = b; addr = a; wdata = d;
        @(negedge clk);
        we = 1'b0; bt = 1'b0;
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a, output logic [15:0] d);
        @(negedge clk);
        re = 1'b1; addr = a;
        @(negedge clk);
        re = 1'b0;
        d = rdata;
    endtask

    task automatic pulse_src(input logic [NIRQ-1:0] s);
        @(negedge clk);
        src = s;
        @(negedge clk);
        src = '0;
    endtask

    initial begin
        logic [15:0] got;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 rvalid in reset", 64'(rvalid), 64'd0);
        chk("R1 irq in reset", 64'(irq), 64'd0);
        chk("R1 timers in reset", 64'(tmr), 64'd0);
        chk("R1 dma in reset", 64'(dcnt), 64'd0);
        // R9 reset value seen by a read on the first edge after release
        rst_n = 1'b1; re = 1'b1; addr = 10'h006;
        @(negedge clk);
        re = 1'b0;
        chk("R9 key reset value", 64'(rdata), 64'h03FF);
        chk("R1 rvalid after read", 64'(rvalid), 64'd1);
        @(negedge clk);
        chk("R1 rvalid drops", 64'(rvalid), 64'd0);
        rd(10'h010, got);
        chk("R1 enable reset zero", 64'(got), 64'h0);

        keys = 10'h2F5; dstat = 3'b101; sstat = 4'hA;
        for (int i = 0; i < NV; i++) begin
            if (VECS[i].wr) begin
                wr(VECS[i].addr, VECS[i].data, VECS[i].bt);
            end else begin
                rd(VECS[i].addr, got);
                chk($sformatf("R%0d vector %0d", VECS[i].req, i), 64'(got), 64'(VECS[i].exp));
            end
        end

        // R7 R8 R10 R11 output ports
        chk("R7 timer0 port", 64'(tmr[15:0]), 64'h00C7);
        chk("R7 timer3 port", 64'(tmr[63:48]), 64'h0083);
        chk("R8 display port", 64'(dctl), 64'h12F8);
        chk("R11 sound port", 64'(sctl), 64'h1230);
        chk("R10 dma port", 64'(dcnt), 64'hABCD);

        // R3 flag set, R2 clear, R4 interrupt
        wr(10'h010, 16'h3FFF, 1'b0);
        pulse_src(14'h0029);
        chk("R4 irq with flags", 64'(irq), 64'd1);
        rd(10'h012, got);
        chk("R3 flags set", 64'(got), 64'h0029);
        wr(10'h012, 16'h0009, 1'b0);
        rd(10'h012, got);
        chk("R2 partial clear", 64'(got), 64'h0020);
        @(negedge clk);
        we = 1'b1; addr = 10'h012; wdata = 16'h0020; src = 14'h0020;
        @(negedge clk);
        we = 1'b0; src = '0;
        rd(10'h012, got);
        chk("R3 set wins over clear", 64'(got), 64'h0020);
        wr(10'h012, 16'h0020, 1'b0);
        chk("R4 irq after clear", 64'(irq), 64'd0);
        pulse_src(14'h0002);
        chk("R4 irq on", 64'(irq), 64'd1);
        wr(10'h014, 16'h0000, 1'b0);
        chk("R4 master off", 64'(irq), 64'd0);
        wr(10'h014, 16'h0001, 1'b0);
        chk("R4 master on", 64'(irq), 64'd1);
        wr(10'h010, 16'h0000, 1'b0);
        chk("R4 enable off", 64'(irq), 64'd0);

        // R6 low-power commands
        wr(10'h016, 16'h007F, 1'b1);
        chk("R6 halt pulse", 64'({halt, stop}), 64'h2);
        @(negedge clk);
        chk("R6 halt ends", 64'({halt, stop}), 64'h0);
        wr(10'h016, 16'h0080, 1'b1);
        chk("R6 stop pulse", 64'({halt, stop}), 64'h1);
        wr(10'h016, 16'h0080, 1'b0);
        chk("R6 halfword ignored", 64'({halt, stop}), 64'h0);
        wr(10'h017, 16'h0080, 1'b1);
        chk("R6 odd byte ignored", 64'({halt, stop}), 64'h0);

        // R12 writes above the map leave registers alone
        wr(10'h010, 16'h0155, 1'b0);
        wr(10'h018, 16'hFFFF, 1'b0);
        wr(10'h210, 16'hFFFF, 1'b0);
        wr(10'h204, 16'h1111, 1'b0);
        rd(10'h010, got);
        chk("R12 enable untouched", 64'(got), 64'h0155);
        chk("R12 dma untouched", 64'(dcnt), 64'hABCD);

        // R9 button change tracked
        keys = 10'h155;
        repeat (2) @(negedge clk);
        rd(10'h006, got);
        chk("R9 keys follow", 64'(got), 64'h0155);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule